// File: doc/BRIEF.md
# SD Command Line Host Engine

This block is the host end of the single-wire command line of an SD/MMC card. On a one-cycle request it builds a 48-bit command frame from a 6-bit command index and a 32-bit argument. It appends a CRC7 and shifts the frame out one bit per clock. It then lets go of the line and waits for the card's short response. The response is shifted in, split into its index and argument fields, and its CRC is checked. One result pulse reports the outcome: normal completion, a response timeout or a CRC error.

Two drive styles are supported, and one is chosen for each command. Open-drain signalling is used while cards are being identified: the host only ever pulls the line low and a pull-up supplies the ones. Push-pull signalling is used once the card holds its relative address. The engine also keeps the protocol's timing. It ignores the turnaround bits just after its own end bit and bounds the wait for the response start bit. It holds off the next command until the minimum idle gap has passed, whether that gap follows a response or follows a command that has no response.

Top module: `sdcmd_host`

## Requirements
- R1: A command accepted on `start` while `busy` is low is sent in the 48 consecutive cycles that follow, most significant bit first. The bits are, in order: a 0 start bit, a 1 direction bit, `cmd_index`, `cmd_arg`, then a CRC7 and a 1 end bit. The CRC7 uses the polynomial x^7+x^3+1 with a zero initial value over the first 40 bits. Index, argument and mode are captured when the command is accepted.
- R2: In push-pull mode (`ident_mode` = 0 at acceptance) `cmd_oe` is high for all 48 bit times. In every mode `cmd_oe` is low from the first bit time after the end bit.
- R3: In open-drain mode (`ident_mode` = 1 at acceptance) `cmd_oe` is high exactly on the 0 bits of the frame, and `cmd_out` is 0 whenever `cmd_oe` is high.
- R4: When a response is expected, a low line during the first two bit times after the end bit (the turnaround bits) is ignored and does not begin a response.
- R5: A response start bit (line low) is accepted at any bit time from 3 through 64 after the command end bit, and a 48-bit response is then read. `done` pulses for one cycle in the cycle after the response end bit. `resp_index` carries response bits 45..40 and `resp_arg` carries bits 39..8, where bit 47 is the response start bit.
- R6: If no start bit is seen by bit time 64, `done` pulses in bit time 65 with `resp_timeout` = 1 and `resp_crc_err` = 0. A start bit at bit time 65 is too late.
- R7: `resp_crc_err` is 1 with `done` when the received 7 CRC bits differ from the CRC7 of the first 40 response bits, and 0 when they match.
- R8: With `resp_expected` = 0 at acceptance, `done` pulses in the first cycle after the command end bit, with both error flags low.
- R9: `busy` stays high for exactly 8 cycles starting with the `done` cycle, after a response, after a timeout and after a command without a response. A `start` raised during that time is ignored and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the command line |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a command, taken when not busy |
| ident_mode | input | 1 | 1 selects open-drain drive, 0 push-pull |
| resp_expected | input | 1 | 1 when the command has a short response |
| cmd_index | input | 6 | Command index field |
| cmd_arg | input | 32 | Command argument field |
| cmd_in | input | 1 | Sampled level of the command line |
| cmd_out | output | 1 | Level driven onto the line while enabled |
| cmd_oe | output | 1 | Output enable of the line driver |
| busy | output | 1 | Command, response or idle gap in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_timeout | output | 1 | No response start bit within the window |
| resp_crc_err | output | 1 | Response CRC mismatch |
| resp_index | output | 6 | Index field of the last response |
| resp_arg | output | 32 | Argument field of the last response |

## Verification
The hardest case to reach from the ports is the edge of the response window. Here the engine must reject a low line in the turnaround bits, accept a start bit on the very last allowed bit time, and give up exactly one bit time later. The bench plays the card. Counting bit times from the command end bit, it drives the line low in the turnaround bits, then starts responses at bit times 3, 10, 20 and 64. It also runs one case with a start bit at bit time 65 and cases that never respond. Each response frame is built in the bench, so a misframed capture shows up as wrong fields or a false CRC error.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_W = 48;
    localparam int BODY_W  = 40;
    localparam int CRC_W   = 7;
    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_WAIT,
        ST_RX,
        ST_GAP
    } sdcmd_state_e;

    // CRC7, polynomial x^7 + x^3 + 1, zero seed, body sent MSB first
    function automatic logic [CRC_W-1:0] crc7_of(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            fb = body[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_tx_ser.sv
module sdcmd_tx_ser
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BODY_W-1:0] body,
    output logic              bit_o
);

    logic [FRAME_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = {body, crc7_of(body), 1'b1};
        end else if (shift) begin
            sh_d = {sh_q[FRAME_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign bit_o = sh_q[FRAME_W-1];

endmodule

// File: rtl/sdcmd_rx_des.sv
module sdcmd_rx_des
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    output logic             crc_ok_pend,
    output logic [IDX_W-1:0] idx_pend,
    output logic [ARG_W-1:0] arg_pend
);

    // Holds every response bit except the end bit; while the end bit is on
    // the line the register contains the whole body and the CRC.
    localparam int HOLD_W = FRAME_W - 1;

    logic [HOLD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d = '0;
        end else if (shift) begin
            sh_d = {sh_q[HOLD_W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign crc_ok_pend = (crc7_of(sh_q[HOLD_W-1:CRC_W]) == sh_q[CRC_W-1:0]);
    assign idx_pend    = sh_q[CRC_W+ARG_W+IDX_W-1:CRC_W+ARG_W];
    assign arg_pend    = sh_q[CRC_W+ARG_W-1:CRC_W];

endmodule

// File: rtl/sdcmd_gap_timer.sv
module sdcmd_gap_timer #(
    parameter int MAX_CNT = 8,
    parameter int GW      = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    output logic          last
);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == GW'(1));

    // R9
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GW'(MAX_CNT));

endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
    import sdcmd_pkg::*;
#(
    parameter int NCR_CYC   = 64,
    parameter int NRC_CYC   = 8,
    parameter int NCC_CYC   = 8,
    parameter int TURN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ident_mode,
    input  logic             resp_expected,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             cmd_in,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic             busy,
    output logic             done,
    output logic             resp_timeout,
    output logic             resp_crc_err,
    output logic [IDX_W-1:0] resp_index,
    output logic [ARG_W-1:0] resp_arg
);

    localparam int CNT_MAX = (NCR_CYC > FRAME_W) ? NCR_CYC : FRAME_W;
    localparam int CW      = $clog2(CNT_MAX) + 1;
    localparam int GMAX    = (NRC_CYC > NCC_CYC) ? NRC_CYC : NCC_CYC;
    localparam int GW      = $clog2(GMAX + 1);

    localparam logic [CW-1:0] LAST_BIT  = CW'(FRAME_W - 1);
    localparam logic [CW-1:0] TURN_END  = CW'(TURN_BITS);
    localparam logic [CW-1:0] WAIT_LAST = CW'(NCR_CYC - 1);
    localparam logic [GW-1:0] NRC_VAL   = GW'(NRC_CYC);
    localparam logic [GW-1:0] NCC_VAL   = GW'(NCC_CYC);

    typedef struct packed {
        sdcmd_state_e     st;
        logic [CW-1:0]    cnt;
        logic             od;
        logic             rexp;
        logic             done;
        logic             tmo;
        logic             crc_err;
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
    } host_regs_t;

    host_regs_t r_d, r_q;

    logic             tx_load, tx_shift, tx_bit;
    logic             rx_clear, rx_shift;
    logic             rx_crc_ok;
    logic [IDX_W-1:0] rx_idx;
    logic [ARG_W-1:0] rx_arg;
    logic             gap_load, gap_last;
    logic [GW-1:0]    gap_val;

    sdcmd_tx_ser u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .shift (tx_shift),
        .body  ({1'b0, 1'b1, cmd_index, cmd_arg}),
        .bit_o (tx_bit)
    );

    sdcmd_rx_des u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (rx_clear),
        .shift       (rx_shift),
        .din         (cmd_in),
        .crc_ok_pend (rx_crc_ok),
        .idx_pend    (rx_idx),
        .arg_pend    (rx_arg)
    );

    sdcmd_gap_timer #(
        .MAX_CNT (GMAX),
        .GW      (GW)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .last     (gap_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        rx_clear = 1'b0;
        rx_shift = 1'b0;
        gap_load = 1'b0;
        gap_val  = NCC_VAL;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_TX;
                    r_d.cnt     = '0;
                    r_d.od      = ident_mode;
                    r_d.rexp    = resp_expected;
                    r_d.tmo     = 1'b0;
                    r_d.crc_err = 1'b0;
                    tx_load     = 1'b1;
                    rx_clear    = 1'b1;
                end
            end
            ST_TX: begin
                tx_shift = 1'b1;
                if (r_q.cnt == LAST_BIT) begin
                    r_d.cnt = '0;
                    if (r_q.rexp) begin
                        r_d.st = ST_WAIT;
                    end else begin
                        r_d.st   = ST_GAP;
                        r_d.done = 1'b1;
                        gap_load = 1'b1;
                        gap_val  = NCC_VAL;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (r_q.cnt >= TURN_END && !cmd_in) begin
                    r_d.st   = ST_RX;
                    r_d.cnt  = CW'(1);
                    rx_shift = 1'b1;
                end else if (r_q.cnt == WAIT_LAST) begin
                    r_d.st   = ST_GAP;
                    r_d.done = 1'b1;
                    r_d.tmo  = 1'b1;
                    gap_load = 1'b1;
                    gap_val  = NCC_VAL;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RX: begin
                rx_shift = 1'b1;
                if (r_q.cnt == LAST_BIT) begin
                    r_d.st      = ST_GAP;
                    r_d.done    = 1'b1;
                    r_d.crc_err = !rx_crc_ok;
                    r_d.idx     = rx_idx;
                    r_d.arg     = rx_arg;
                    gap_load    = 1'b1;
                    gap_val     = NRC_VAL;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (gap_last) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign cmd_out      = (r_q.st == ST_TX) ? tx_bit : 1'b1;
    assign cmd_oe       = (r_q.st == ST_TX) && (!r_q.od || !tx_bit);
    assign done         = r_q.done;
    assign resp_timeout = r_q.tmo;
    assign resp_crc_err = r_q.crc_err;
    assign resp_index   = r_q.idx;
    assign resp_arg     = r_q.arg;

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (cmd_oe && !cmd_out));

    // R2
    turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> !cmd_oe);

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(resp_timeout && resp_crc_err));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(r_q.st == ST_GAP));

endmodule

// File: tb/sdcmd_host_tb.sv
module sdcmd_host_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCR  = 64;
    localparam int NRC  = 8;
    localparam int NCC  = 8;
    localparam int TURN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ident_mode = 1'b0;
    logic        resp_expected = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, busy, done, resp_timeout, resp_crc_err;
    logic [5:0]  resp_index;
    logic [31:0] resp_arg;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_host u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ident_mode(ident_mode),
        .resp_expected(resp_expected), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
        .done(done), .resp_timeout(resp_timeout), .resp_crc_err(resp_crc_err),
        .resp_index(resp_index), .resp_arg(resp_arg)
    );

    // remainder of polynomial long division by 0x89
    function automatic logic [6:0] ref_crc(input logic [39:0] b);
        logic [46:0] v;
        v = {b, 7'b0};
        for (int i = 46; i >= 7; i--) begin
            if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
        end
        return v[6:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit od, input bit rexp, input logic [5:0] idx, input logic [31:0] arg);
        logic [47:0] exp_f;
        logic [47:0] seen;
        bit drv_ok;
        drv_ok = 1;
        exp_f = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
        @(negedge clk);
        start = 1; ident_mode = od; resp_expected = rexp; cmd_index = idx; cmd_arg = arg;
        @(negedge clk);
        start = 0; ident_mode = ~od; resp_expected = ~rexp; cmd_index = ~idx; cmd_arg = ~arg;
        for (int k = 0; k < 48; k++) begin
            if (k > 0) @(negedge clk);
            seen[47-k] = cmd_oe ? cmd_out : 1'b1;
            if (od) begin
                if (cmd_oe !== (exp_f[47-k] == 1'b0)) drv_ok = 0;
                if (cmd_oe && cmd_out !== 1'b0) drv_ok = 0;
            end else if (cmd_oe !== 1'b1) drv_ok = 0;
        end
        chk(seen === exp_f, "R1 frame", seen, exp_f);
        if (od) chk(drv_ok, "R3 open-drain enable pattern", drv_ok, 1);
        else    chk(drv_ok, "R2 push-pull enable", drv_ok, 1);
    endtask

    // called in the done cycle; also pokes start to confirm it is ignored
    task automatic gap(input int exp_n, input string req);
        int n;
        bit oe_seen;
        n = 0; oe_seen = 0;
        cmd_in = 1;
        start = 1;
        while (busy === 1'b1 && n < 200) begin
            n++;
            if (cmd_oe) oe_seen = 1;
            @(negedge clk);
            start = 0;
        end
        chk(n == exp_n, req, n, exp_n);
        @(negedge clk);
        chk(!oe_seen && busy === 1'b0 && cmd_oe === 1'b0, "R9 start in gap ignored", busy, 0);
    endtask

    task automatic respond(input int d, input bit glitch, input bit bad,
                           input logic [5:0] ridx, input logic [31:0] rarg, input string tag);
        logic [47:0] rf;
        logic [6:0]  c;
        bit early, oe_bad;
        early = 0; oe_bad = 0;
        c  = ref_crc({2'b00, ridx, rarg}) ^ (bad ? 7'h10 : 7'h00);
        rf = {2'b00, ridx, rarg, c, 1'b1};
        for (int bt = 1; bt <= d + 47; bt++) begin
            @(negedge clk);
            if (done) early = 1;
            if (bt <= TURN && cmd_oe) oe_bad = 1;
            if (bt < d) cmd_in = (glitch && bt <= TURN) ? 1'b0 : 1'b1;
            else        cmd_in = rf[47-(bt-d)];
        end
        @(negedge clk);
        cmd_in = 1;
        chk(!early && done === 1'b1, {tag, " R5 done after end bit"}, done, 1);
        chk(resp_index === ridx && resp_arg === rarg, {tag, " R5 fields"},
            {resp_index, resp_arg}, {ridx, rarg});
        chk(resp_crc_err === bad, {tag, " R7 crc flag"}, resp_crc_err, bad);
        chk(resp_timeout === 1'b0, {tag, " R6 no timeout"}, resp_timeout, 0);
        chk(!oe_bad, "R2 line released after end bit", oe_bad, 0);
        gap(NRC, "R9 gap after response");
    endtask

    task automatic no_answer(input bit glitch, input bit late0);
        bit early;
        early = 0;
        for (int bt = 1; bt <= NCR; bt++) begin
            @(negedge clk);
            if (done) early = 1;
            cmd_in = (glitch && bt <= TURN) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        cmd_in = late0 ? 1'b0 : 1'b1;
        chk(!early && done === 1'b1 && resp_timeout === 1'b1 && resp_crc_err === 1'b0,
            glitch ? "R4 turnaround low then R6 timeout" : (late0 ? "R6 late start" : "R6 timeout"),
            {early, done, resp_timeout, resp_crc_err}, 4'b0110);
        gap(NCC, "R9 gap after timeout");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && cmd_oe === 0 && cmd_out === 1 &&
            resp_timeout === 0 && resp_crc_err === 0, "reset state",
            {busy, done, cmd_oe, cmd_out}, 4'b0001);
        rst_n = 1;
        @(negedge clk);

        // R1 bench CRC against a known frame (index 0, argument 0 -> CRC 0x4A)
        chk(ref_crc(40'h40_0000_0000) == 7'h4A, "R1 crc reference", ref_crc(40'h4000000000), 7'h4A);

        // R1 R2 R3 R8 sweep of every index without response
        for (int i = 0; i < 64; i++) begin
            issue(i[0], 0, i[5:0], 32'h9E37_79B1 * (i + 1) ^ {i[7:0], 24'h5A0F3C});
            @(negedge clk);
            chk(done === 1 && resp_timeout === 0 && resp_crc_err === 0,
                "R8 done after end bit", {done, resp_timeout, resp_crc_err}, 3'b100);
            gap(NCC, "R9 gap after command");
        end

        // R5 R7 R4 responses in both drive modes
        issue(0, 1, 6'd17, 32'h0000_1234);
        respond(3,  0, 0, 6'd17, 32'h0000_0900, "earliest");
        issue(1, 1, 6'd2,  32'hFFFF_FFFF);
        respond(10, 0, 0, 6'd63, 32'hA5A5_5A5A, "mid");
        issue(0, 1, 6'd55, 32'h8000_0001);
        respond(NCR, 0, 0, 6'd0, 32'h0000_0000, "latest");
        issue(1, 1, 6'd3,  32'h0001_0000);
        respond(3,  1, 0, 6'd3, 32'hDEAD_BEEF, "R4 turnaround low start3");
        issue(0, 1, 6'd7,  32'h0F0F_F0F0);
        respond(20, 1, 0, 6'd7, 32'h1357_9BDF, "R4 turnaround low start20");
        issue(0, 1, 6'd13, 32'h2468_ACE0);
        respond(5,  0, 1, 6'd13, 32'hCAFE_F00D, "bad crc");
        issue(1, 1, 6'd41, 32'h7777_0000);
        respond(4,  0, 1, 6'd41, 32'h0000_0001, "bad crc od");

        // R6 timeout cases
        issue(0, 1, 6'd8, 32'h0000_01AA);
        no_answer(0, 0);
        issue(1, 1, 6'd1, 32'h00FF_8000);
        no_answer(1, 0);
        issue(0, 1, 6'd9, 32'h1234_5678);
        no_answer(0, 1);

        // normal response after a timeout still works
        issue(0, 1, 6'd16, 32'h0000_0200);
        respond(6, 0, 0, 6'd16, 32'h0000_0900, "after timeout");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule